// File: doc/BRIEF.md
# Word Clock Rate Detector

This block watches an asynchronous word clock from outside the chip and times it against a free-running reference clock. It counts reference cycles between rising edges of the word clock. It then checks whether that period matches one of six standard audio sample rates, each allowed a ±3% error. A rate is only trusted after several matching periods in a row. Once trusted, the block reports the rate code and lets the outputs follow the incoming rate.

When no trusted rate exists, the block falls back to a safe state:
- the status light is driven red;
- the outgoing word clock rate is forced to the 48 kHz code;
- the digital outputs are asked to mute.

The same fallback applies in three cases: after reset, after the input goes silent for too long, and while the incoming rate is changing from one standard value to another.

Top module: `wclk_rate_detect`

## Requirements
- R1: After reset, `lock_o`=0, `led_red_o`=1, `mute_o`=1, `out_rate_o`=1 (the 48 kHz code) and `det_rate_o`=7 (the "no rate" code).
- R2: The rate codes are 0=44.1 kHz, 1=48 kHz, 2=88.2 kHz, 3=96 kHz, 4=176.4 kHz and 5=192 kHz. A steady word clock at any of these rates leads to lock, and both `det_rate_o` and `out_rate_o` then carry that rate's code.
- R3: The acceptance window for a rate runs from ceil(0.97·REF_HZ/rate) to floor(1.03·REF_HZ/rate) reference cycles. A period 2% off nominal still locks. A period 5% off every nominal never locks.
- R4: Lock needs 4 consecutive measured periods in the same rate's window. Only 3 such periods leave the block unlocked.
- R5: While locked, a single period outside the locked window keeps lock. Two consecutive periods outside it drop lock.
- R6: While unlocked, `led_red_o`=1, `mute_o`=1, `out_rate_o`=1 and `det_rate_o`=7. While locked, `led_red_o`=0 and `mute_o`=0.
- R7: If no rising edge arrives for TIMEOUT = floor(5/4 · the 44.1 kHz upper bound) reference cycles, lock drops without waiting for any further period. Lock is still held before that point.
- R8: A change from one valid rate to another goes through the unlocked state. `det_rate_o` never changes value while `lock_o` stays high.
- R9: The first rising edge after reset or after a timeout only starts a measurement. It is not taken as a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Incoming word clock, asynchronous to clk |
| lock_o | output | 1 | High while a supported rate is locked |
| led_red_o | output | 1 | Drives the status light red while unlocked |
| det_rate_o | output | 3 | Detected rate code 0..5, or 7 when unlocked |
| out_rate_o | output | 3 | Rate code selected for the outgoing clocks; 1 when unlocked |
| mute_o | output | 1 | Requests muting of the digital outputs |

## Verification
The bench drives periods just inside the ±3% window and 5% outside it, so that a design with a wrong bound or an off-by-one in the period count either never locks or locks on bad input. It stops after 3 matching periods and checks that lock has not yet arrived, which catches a short qualification counter. It sends one bad period and then two, which separates a design that drops lock on the first miss from one that never drops. It also stops the word clock and checks lock both before and after the timeout, which exposes a timer that is missing or fires too early. While the rate changes from 48 kHz to 96 kHz, a per-cycle monitor looks for any change of the reported rate while lock is held.

// File: rtl/wcrd_pkg.sv
package wcrd_pkg;
  localparam int NUM_RATES = 6;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_FALLBACK = 3'd1;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;

  function automatic longint rate_hz(input int idx);
    case (idx)
      0: return 64'd44100;
      1: return 64'd48000;
      2: return 64'd88200;
      3: return 64'd96000;
      4: return 64'd176400;
      default: return 64'd192000;
    endcase
  endfunction

  // smallest accepted period in reference cycles (rounded up)
  function automatic longint win_lo(input longint ref_hz, input int idx, input int tol_pct);
    longint den;
    den = 64'd100 * rate_hz(idx);
    return (ref_hz * longint'(100 - tol_pct) + den - 1) / den;
  endfunction

  // largest accepted period in reference cycles (rounded down)
  function automatic longint win_hi(input longint ref_hz, input int idx, input int tol_pct);
    return (ref_hz * longint'(100 + tol_pct)) / (64'd100 * rate_hz(idx));
  endfunction
endpackage

// File: rtl/wcrd_sync_edge.sv
module wcrd_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      s1 <= async_i;
      s2 <= s1;
      s3 <= s2;
      rise_o <= s2 & ~s3;
    end
  end

  // R9
  rise_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wcrd_period_meter.sv
module wcrd_period_meter #(
  parameter int TIMEOUT = 1000,
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      armed <= 1'b0;
      meas_valid_o <= 1'b0;
      meas_o <= '0;
      timeout_o <= 1'b0;
    end else begin
      meas_valid_o <= 1'b0;
      timeout_o <= 1'b0;
      if (rise_i) begin
        if (armed) begin
          meas_valid_o <= 1'b1;
          meas_o <= cnt + 1'b1;
        end
        armed <= 1'b1;
        cnt <= '0;
      end else if (armed) begin
        if (cnt == CNT_W'(TIMEOUT - 1)) begin
          armed <= 1'b0;
          timeout_o <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9
  rearm_after_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !meas_valid_o);
endmodule

// File: rtl/wcrd_classifier.sv
module wcrd_classifier
  import wcrd_pkg::*;
#(
  parameter int REF_HZ = 125_000_000,
  parameter int TOL_PCT = 3,
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid_i,
  input  logic [CNT_W-1:0]  meas_i,
  output logic              cls_valid_o,
  output logic              cls_hit_o,
  output logic [CODE_W-1:0] cls_idx_o
);
  logic [NUM_RATES-1:0] in_win;
  logic [CODE_W-1:0]    hit_idx;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(win_lo(longint'(REF_HZ), g, TOL_PCT));
    localparam logic [CNT_W-1:0] HI = CNT_W'(win_hi(longint'(REF_HZ), g, TOL_PCT));
    assign in_win[g] = (meas_i >= LO) && (meas_i <= HI);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (in_win[i]) hit_idx = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_valid_o <= 1'b0;
      cls_hit_o <= 1'b0;
      cls_idx_o <= '0;
    end else begin
      cls_valid_o <= meas_valid_i;
      if (meas_valid_i) begin
        cls_hit_o <= |in_win;
        cls_idx_o <= hit_idx;
      end
    end
  end

  // R3
  disjoint_windows_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_win));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    meas_valid_i |=> cls_valid_o && (!cls_hit_o || cls_idx_o < CODE_W'(NUM_RATES)));
endmodule

// File: rtl/wcrd_lock_fsm.sv
module wcrd_lock_fsm
  import wcrd_pkg::*;
#(
  parameter int LOCK_N = 4,
  parameter int DROP_N = 2,
  localparam int LOCK_W = $clog2(LOCK_N + 1),
  localparam int DROP_W = $clog2(DROP_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cls_valid_i,
  input  logic              cls_hit_i,
  input  logic [CODE_W-1:0] cls_idx_i,
  input  logic              timeout_i,
  output logic              locked_o,
  output logic [CODE_W-1:0] cand_o
);
  logic [LOCK_W-1:0] good_cnt;
  logic [DROP_W-1:0] bad_cnt;
  logic              match;

  assign match = cls_hit_i && (cls_idx_i == cand_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o <= 1'b0;
      cand_o <= CODE_FALLBACK;
      good_cnt <= '0;
      bad_cnt <= '0;
    end else if (timeout_i) begin
      locked_o <= 1'b0;
      good_cnt <= '0;
      bad_cnt <= '0;
    end else if (cls_valid_i) begin
      if (!locked_o) begin
        if (cls_hit_i && (match || good_cnt == '0)) begin
          cand_o <= cls_idx_i;
          if (good_cnt == LOCK_W'(LOCK_N - 1)) begin
            locked_o <= 1'b1;
            good_cnt <= '0;
            bad_cnt <= '0;
          end else begin
            good_cnt <= good_cnt + 1'b1;
          end
        end else if (cls_hit_i) begin
          cand_o <= cls_idx_i;
          good_cnt <= LOCK_W'(1);
        end else begin
          good_cnt <= '0;
        end
      end else begin
        if (match) begin
          bad_cnt <= '0;
        end else if (bad_cnt == DROP_W'(DROP_N - 1)) begin
          locked_o <= 1'b0;
          bad_cnt <= '0;
          good_cnt <= '0;
        end else begin
          bad_cnt <= bad_cnt + 1'b1;
        end
      end
    end
  end

  // R7
  timeout_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_i |=> !locked_o);

  // R4
  lock_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(cls_valid_i && cls_hit_i) && cand_o == $past(cls_idx_i));

  // R5
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> $past(timeout_i || (cls_valid_i && !(cls_hit_i && cls_idx_i == cand_o))));

  // R8
  cand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o && $past(locked_o) |-> $stable(cand_o));
endmodule

// File: rtl/wclk_rate_detect.sv
module wclk_rate_detect
  import wcrd_pkg::*;
#(
  parameter int REF_HZ = 125_000_000,
  parameter int TOL_PCT = 3,
  parameter int LOCK_N = 4,
  parameter int DROP_N = 2,
  localparam int TIMEOUT = int'((win_hi(longint'(REF_HZ), 0, TOL_PCT) * 5) / 4),
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wclk_i,
  output logic        lock_o,
  output logic        led_red_o,
  output logic [2:0]  det_rate_o,
  output logic [2:0]  out_rate_o,
  output logic        mute_o
);
  logic              rise;
  logic              meas_valid;
  logic [CNT_W-1:0]  meas;
  logic              timeout;
  logic              cls_valid;
  logic              cls_hit;
  logic [CODE_W-1:0] cls_idx;
  logic              locked;
  logic [CODE_W-1:0] cand;

  wcrd_sync_edge u_sync (
    .clk(clk), .rst(rst), .async_i(wclk_i), .rise_o(rise)
  );

  wcrd_period_meter #(.TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk), .rst(rst), .rise_i(rise),
    .meas_valid_o(meas_valid), .meas_o(meas), .timeout_o(timeout)
  );

  wcrd_classifier #(.REF_HZ(REF_HZ), .TOL_PCT(TOL_PCT), .CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst(rst), .meas_valid_i(meas_valid), .meas_i(meas),
    .cls_valid_o(cls_valid), .cls_hit_o(cls_hit), .cls_idx_o(cls_idx)
  );

  wcrd_lock_fsm #(.LOCK_N(LOCK_N), .DROP_N(DROP_N)) u_fsm (
    .clk(clk), .rst(rst), .cls_valid_i(cls_valid), .cls_hit_i(cls_hit),
    .cls_idx_i(cls_idx), .timeout_i(timeout), .locked_o(locked), .cand_o(cand)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o <= 1'b0;
      led_red_o <= 1'b1;
      det_rate_o <= CODE_NONE;
      out_rate_o <= CODE_FALLBACK;
      mute_o <= 1'b1;
    end else begin
      lock_o <= locked;
      led_red_o <= ~locked;
      det_rate_o <= locked ? cand : CODE_NONE;
      out_rate_o <= locked ? cand : CODE_FALLBACK;
      mute_o <= ~locked;
    end
  end

  // R6
  fallback_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_o |-> mute_o && led_red_o && out_rate_o == CODE_FALLBACK && det_rate_o == CODE_NONE);

  // R8
  det_rate_stable_chk: assert property (@(posedge clk) disable iff (rst)
    lock_o && $past(lock_o) |-> $stable(det_rate_o));
endmodule

// File: tb/wclk_rate_detect_test.sv
`timescale 1ns/1ps
module wclk_rate_detect_test;
  localparam int REF = 25_000_000;
  // 44.1 kHz upper bound floor(25e6*1.03/44100) = 583; timeout = 583*5/4 = 728
  localparam int TMO = 728;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wclk = 1'b0;
  logic lock, red, mute;
  logic [2:0] det, outr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wclk_rate_detect #(.REF_HZ(REF)) uut (
    .clk(clk), .rst(rst), .wclk_i(wclk), .lock_o(lock), .led_red_o(red),
    .det_rate_o(det), .out_rate_o(outr), .mute_o(mute)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R8 monitor: reported rate must not move while lock stays high
  logic prev_lock = 1'b0;
  logic [2:0] prev_det = 3'd7;
  int r8_viol = 0;
  always @(negedge clk) begin
    if (!rst && prev_lock && lock && det != prev_det) r8_viol++;
    prev_lock <= lock;
    prev_det <= det;
  end

  task automatic do_reset();
    wclk = 1'b0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // n rising edges, each followed by one full period of p reference cycles
  task automatic run_wclk(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      wclk = 1'b1;
      repeat (p / 2) @(negedge clk);
      wclk = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic chk_unlocked(input string req);
    chk(req, lock, 0);
    chk(req, red, 1);
    chk(req, mute, 1);
    chk(req, outr, 1);
    chk(req, det, 7);
  endtask

  task automatic chk_locked(input string req, input int code);
    chk(req, lock, 1);
    chk(req, red, 0);
    chk(req, mute, 0);
    chk(req, det, code);
    chk(req, outr, code);
  endtask

  task automatic t_reset();
    do_reset();
    chk_unlocked("R1 reset state");
  endtask

  task automatic t_all_rates();
    int per[6] = '{567, 521, 283, 260, 142, 130};
    for (int i = 0; i < 6; i++) begin
      do_reset();
      run_wclk(per[i], 5);
      chk_locked($sformatf("R2 rate code %0d", i), i);
    end
  endtask

  task automatic t_qualify();
    do_reset();
    run_wclk(521, 4);
    chk_unlocked("R4 three periods only");
    chk_unlocked("R9 first edge not a period");
    run_wclk(521, 1);
    chk_locked("R4 four periods", 1);
  endtask

  task automatic t_window();
    do_reset();
    run_wclk(531, 5);
    chk_locked("R3 +2% accepted", 1);
    do_reset();
    run_wclk(510, 5);
    chk_locked("R3 -2% accepted", 1);
    do_reset();
    run_wclk(547, 7);
    chk_unlocked("R3 +5% rejected");
    chk_unlocked("R6 fallback on no match");
    do_reset();
    run_wclk(495, 7);
    chk_unlocked("R3 -5% rejected");
  endtask

  task automatic t_drop();
    do_reset();
    run_wclk(521, 5);
    chk_locked("R5 setup", 1);
    run_wclk(547, 1);
    run_wclk(521, 1);
    chk_locked("R5 single miss held", 1);
    run_wclk(547, 2);
    run_wclk(521, 1);
    chk_unlocked("R5 two misses drop");
  endtask

  task automatic t_change();
    do_reset();
    r8_viol = 0;
    run_wclk(521, 5);
    chk_locked("R8 start at 48k", 1);
    run_wclk(260, 3);
    chk_unlocked("R8 unlocked during change");
    run_wclk(260, 4);
    chk_locked("R8 relock at 96k", 3);
    chk("R8 no rate switch while locked", r8_viol, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    run_wclk(521, 5);
    // 521 cycles since the last edge; wait to 621 total
    repeat (100) @(negedge clk);
    chk_locked("R7 held before timeout", 1);
    repeat (TMO + 50 - 621) @(negedge clk);
    chk_unlocked("R7 timeout drop");
    run_wclk(521, 4);
    chk_unlocked("R9 restart after timeout needs four periods");
    run_wclk(521, 1);
    chk_locked("R9 relock after timeout", 1);
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_all_rates();
    t_window();
    t_drop();
    t_change();
    t_timeout();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule